// File: doc/BRIEF.md
# Double-Buffered Longitudinal Time Code Frame Generator

The block serialises one longitudinal time code frame at a time as a biphase-mark level on a single digital output. A frame is 80 bit cells long. The first 64 cells carry a data word that software writes into a staging register outside the block. The last 16 cells carry a fixed forward sync word, which the block supplies itself.

Each frame begins on a start strobe. The strobe comes from whichever sync source the surrounding logic has chosen: video timing, an external click, or a free-running divider. The cell rate follows a two-bit frame-rate select and is derived from the system clock by a fractional accumulator, so the drop-frame rate keeps exact average timing.

The staging word moves into an internal output buffer at one fixed late point in every transmitted frame, and a one-cycle interrupt marks that move. Data written after the interrupt is therefore sent two frames later. Software uses the interrupt as its cue to reload the staging register.

Top module: `ltc_frame_gen`

## Requirements
- R1: After reset, `ltc_o` and `irq_o` are low and the output buffer holds all zeros, so the first frame sent after reset carries 64 zero data bits.
- R2: While enabled, no frame starts without a start strobe. A strobe is remembered until a frame starts, and that frame begins on the first half-cell tick after the strobe. A strobe that arrives during a frame makes the next frame follow with no gap.
- R3: Frame cell k (0 to 63) carries bit k of `stage_i` unmodified. Byte j of the staging word is `stage_i[8j+7:8j]`, so the least significant bit of byte 0 is cell 0 and the most significant bit of byte 7 is cell 63.
- R4: Cells 64 to 79 carry the sync word 0,0, then twelve 1s, then 0,1, in that transmission order.
- R5: Every cell starts with a toggle of `ltc_o`. A cell that carries a 1 toggles again at mid-cell. No other toggles occur.
- R6: When the half-cell tick that ends cell 71 arrives with `tx_en_i` high, the staging word is copied to the output buffer. In the same clock `irq_o` pulses high for exactly one cycle, together with the toggle that opens cell 72.
- R7: A staging word written after the interrupt of frame N is first sent in frame N+2. Frame N+1 carries the word that was present at the interrupt of frame N.
- R8: While `tx_en_i` is low, no frame starts, no transfer takes place, no interrupt fires, and strobes are discarded. A frame already in progress still completes all 80 cells.
- R9: `rate_sel_i` encodes 0 = 24, 1 = 25, 2 = 29.97 (30000/1001), 3 = 30 frames per second. Half-cell ticks occur at 160 times the frame rate, averaged exactly over the system clock `CLK_HZ`.
- R10: When a frame ends and no strobe is pending, `ltc_o` holds its level and no toggles occur until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_en_i | input | 1 | Transmit enable |
| rate_sel_i | input | 2 | Frame-rate select (0: 24, 1: 25, 2: 29.97, 3: 30 fps) |
| start_i | input | 1 | Frame-start strobe from the chosen sync source |
| stage_i | input | 64 | Staging data word, bit k goes to cell k |
| ltc_o | output | 1 | Biphase-mark serial time code |
| irq_o | output | 1 | One-cycle transmit interrupt at the buffer transfer |

## Verification
The bench builds the block with `CLK_HZ` set to 19200. With that value the half cell lasts exactly 4 clocks at 30 fps and exactly 5 clocks at 24 fps, so the bench can decode frames from the gaps between edges and predict the interrupt cycle exactly. At 25 fps a half cell averages 4.8 clocks, which makes a frame exactly 768 clocks. At 29.97 fps individual frames last 640 or 641 clocks, and 25 of them sum to exactly 16016 clocks. The exact drop-frame averaging can therefore be checked within a short run.

// File: rtl/ltc_gen_pkg.sv
package ltc_gen_pkg;

  typedef enum logic [1:0] {
    RATE_24   = 2'd0,
    RATE_25   = 2'd1,
    RATE_2997 = 2'd2,
    RATE_30   = 2'd3
  } ltc_rate_e;

  localparam int unsigned DATA_BITS  = 64;
  localparam int unsigned SYNC_BITS  = 16;
  localparam int unsigned CELLS      = DATA_BITS + SYNC_BITS;
  localparam int unsigned CELL_W     = $clog2(CELLS);
  localparam int unsigned DIDX_W     = $clog2(DATA_BITS);
  localparam int unsigned SIDX_W     = $clog2(SYNC_BITS);
  localparam int unsigned XFER_CELL  = 71;
  localparam int unsigned HALVES     = 2 * CELLS;
  // bit k is sent in cell DATA_BITS+k
  localparam logic [SYNC_BITS-1:0] SYNC_WORD = 16'hBFFC;

  // frame rate scaled by 1001 so that 30000/1001 stays integral
  function automatic longint unsigned fps_x1001(ltc_rate_e r);
    case (r)
      RATE_24:   return 64'd24024;
      RATE_25:   return 64'd25025;
      RATE_2997: return 64'd30000;
      default:   return 64'd30030;
    endcase
  endfunction

endpackage

// File: rtl/ltc_half_cell_clock.sv
module ltc_half_cell_clock
  import ltc_gen_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 27_000_000
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  ltc_rate_e rate_i,
  output logic      tick_o
);

  localparam longint unsigned MODULUS = CLK_HZ * 64'd1001;
  localparam int unsigned     ACC_W   = $clog2(MODULUS) + 2;

  logic [ACC_W-1:0] acc_q, inc, sum;
  logic             hit;

  always_comb begin
    inc = ACC_W'(64'(HALVES) * fps_x1001(rate_i));
    sum = acc_q + inc;
    hit = sum >= ACC_W'(MODULUS);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      acc_q  <= hit ? (sum - ACC_W'(MODULUS)) : sum;
      tick_o <= hit;
    end
  end

endmodule

// File: rtl/ltc_frame_seq.sv
module ltc_frame_seq
  import ltc_gen_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 tx_en_i,
  input  logic                 start_i,
  input  logic [DATA_BITS-1:0] stage_i,
  output logic                 busy_o,
  output logic                 cell_edge_o,
  output logic                 mid_edge_o,
  output logic                 irq_o
);

  logic [DATA_BITS-1:0] out_buf_q;
  logic [CELL_W-1:0]    cell_q;
  logic                 half_q, busy_q, pend_q, irq_q;
  logic [SIDX_W-1:0]    sync_idx;
  logic                 cur_bit, last_cell, xfer_cell;
  logic                 launch, step_cell, xfer;

  always_comb begin
    sync_idx  = SIDX_W'(cell_q - CELL_W'(DATA_BITS));
    cur_bit   = (cell_q < CELL_W'(DATA_BITS)) ? out_buf_q[cell_q[DIDX_W-1:0]]
                                              : SYNC_WORD[sync_idx];
    last_cell = cell_q == CELL_W'(CELLS - 1);
    xfer_cell = cell_q == CELL_W'(XFER_CELL);
    // back-to-back start reuses the final half tick of the previous frame
    launch      = tick_i & pend_q & tx_en_i & (~busy_q | (half_q & last_cell));
    step_cell   = tick_i & busy_q & half_q & ~last_cell;
    xfer        = tick_i & busy_q & half_q & xfer_cell & tx_en_i;
    mid_edge_o  = tick_i & busy_q & ~half_q & cur_bit;
    cell_edge_o = launch | step_cell;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cell_q <= '0;
      half_q <= 1'b0;
    end else if (launch) begin
      busy_q <= 1'b1;
      cell_q <= '0;
      half_q <= 1'b0;
    end else if (tick_i && busy_q) begin
      if (!half_q) begin
        half_q <= 1'b1;
      end else if (last_cell) begin
        busy_q <= 1'b0;
      end else begin
        cell_q <= cell_q + 1'b1;
        half_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      irq_q     <= 1'b0;
      out_buf_q <= '0;
    end else begin
      pend_q <= tx_en_i & (start_i | (pend_q & ~launch));
      irq_q  <= xfer;
      if (xfer) out_buf_q <= stage_i;
    end
  end

  assign busy_o = busy_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/ltc_biphase_out.sv
module ltc_biphase_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cell_edge_i,
  input  logic mid_edge_i,
  output logic level_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_o <= 1'b0;
    else         level_o <= level_o ^ (cell_edge_i | mid_edge_i);
  end

endmodule

// File: rtl/ltc_frame_gen.sv
module ltc_frame_gen
  import ltc_gen_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 27_000_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tx_en_i,
  input  logic [1:0]  rate_sel_i,
  input  logic        start_i,
  input  logic [63:0] stage_i,
  output logic        ltc_o,
  output logic        irq_o
);

  logic tick_w, busy_w, cell_edge_w, mid_edge_w;

  ltc_half_cell_clock #(.CLK_HZ(CLK_HZ)) u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rate_i (ltc_rate_e'(rate_sel_i)),
    .tick_o (tick_w)
  );

  ltc_frame_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_w),
    .tx_en_i     (tx_en_i),
    .start_i     (start_i),
    .stage_i     (stage_i),
    .busy_o      (busy_w),
    .cell_edge_o (cell_edge_w),
    .mid_edge_o  (mid_edge_w),
    .irq_o       (irq_o)
  );

  ltc_biphase_out u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cell_edge_i (cell_edge_w),
    .mid_edge_i  (mid_edge_w),
    .level_o     (ltc_o)
  );

endmodule

// File: rtl/ltc_frame_gen_sva.sv
module ltc_frame_gen_sva (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_en_i,
  input logic tick_i,
  input logic busy_i,
  input logic ltc_i,
  input logic irq_i
);

  assert_irq_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !irq_i);

  assert_irq_in_frame_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> $past(busy_i));

  assert_irq_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> $past(tx_en_i));

  assert_tick_aligned_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ltc_i != $past(ltc_i)) |-> $past(tick_i));

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !$past(busy_i)) |-> $stable(ltc_i));

endmodule

bind ltc_frame_gen ltc_frame_gen_sva u_sva (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tx_en_i (tx_en_i),
  .tick_i  (tick_w),
  .busy_i  (busy_w),
  .ltc_i   (ltc_o),
  .irq_i   (irq_o)
);

// File: tb/ltc_frame_gen_test.sv
module ltc_frame_gen_test;

  localparam longint unsigned CLK_HZ = 19200;
  localparam logic [15:0] SYNC_EXP = 16'hBFFC;
  localparam int HB = 4;  // half cell at 30 fps
  localparam int EN = 2048;

  logic        clk = 1'b0, rst_n = 1'b0, tx_en = 1'b0, start = 1'b0;
  logic [1:0]  rate = 2'd3;
  logic [63:0] stage = '0;
  logic        ltc, irq;

  localparam logic [63:0] PAT_A = 64'h8877_6655_4433_2201;
  localparam logic [63:0] PAT_C = 64'hF0E1_D2C3_B4A5_9687;
  localparam logic [63:0] PAT_D = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] PAT_E = 64'hAAAA_5555_FFFF_0000;
  localparam logic [63:0] PAT_F = 64'h1357_9BDF_2468_ACE0;

  always #10 clk = ~clk;

  ltc_frame_gen #(.CLK_HZ(CLK_HZ)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .rate_sel_i(rate),
    .start_i(start), .stage_i(stage), .ltc_o(ltc), .irq_o(irq)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int   edge_t[EN];
  int   n_edge = 0;
  int   irq_t[64];
  int   n_irq = 0;
  logic last_lvl = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ltc !== last_lvl) begin
        edge_t[n_edge % EN] = cyc;
        n_edge = n_edge + 1;
      end
      last_lvl = ltc;
      if (irq === 1'b1) begin
        irq_t[n_irq % 64] = cyc;
        n_irq = n_irq + 1;
      end
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_n(input int n);
    repeat (n) step();
  endtask

  function automatic int edge_at(input int j);
    return edge_t[j % EN];
  endfunction

  function automatic int find_edge(input int t);
    for (int j = n_edge - 1; j >= 0 && j >= n_edge - EN; j--)
      if (edge_at(j) == t) return j;
    return -1;
  endfunction

  task automatic pulse_start(output int sc);
    start = 1'b1;
    sc = cyc;
    step();
    start = 1'b0;
  endtask

  task automatic wait_edge(input int base, output int t);
    for (int k = 0; k < 50 && n_edge <= base; k++) step();
    t = (n_edge > base) ? edge_at(base) : -1;
  endtask

  task automatic decode(input int t0, output logic [79:0] bits, output bit ok);
    int j;
    int gap;
    j = find_edge(t0);
    ok = (j >= 0);
    bits = '0;
    for (int k = 0; k < 80; k++) begin
      if (!ok) break;
      if (j + 1 >= n_edge) begin
        ok = 1'b0;
        break;
      end
      gap = edge_at(j + 1) - edge_at(j);
      if (gap == HB) begin
        bits[k] = 1'b1;
        j += 2;
      end else if (gap == 2 * HB) begin
        bits[k] = 1'b0;
        j += 1;
      end else begin
        ok = 1'b0;
      end
    end
  endtask

  task automatic check_frame(input int t0, input logic [63:0] exp, input string req);
    logic [79:0] bits;
    bit ok;
    decode(t0, bits, ok);
    chk(ok, "R5 biphase cell timing", ok, 1);
    chk(bits[63:0] == exp, req, bits[63:0], exp);
    chk(bits[79:64] == SYNC_EXP, "R4 sync word", bits[79:64], SYNC_EXP);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    wait_n(3);
    chk(ltc == 1'b0, "R1 ltc low in reset", ltc, 0);
    chk(irq == 1'b0, "R1 irq low in reset", irq, 0);
    rst_n = 1'b1;
    wait_n(2);
  endtask

  task automatic t_gating();
    int eb, ib, sc;
    eb = n_edge;
    ib = n_irq;
    tx_en = 1'b0;
    pulse_start(sc);
    wait_n(1200);
    chk(n_edge == eb, "R8 no frame while disabled", n_edge - eb, 0);
    chk(n_irq == ib, "R8 no irq while disabled", n_irq - ib, 0);
    tx_en = 1'b1;
    wait_n(1000);
    chk(n_edge == eb, "R2 no frame without strobe", n_edge - eb, 0);
  endtask

  task automatic t_first_frame();
    int eb, ib, sc, e0;
    stage = PAT_A;
    eb = n_edge;
    ib = n_irq;
    pulse_start(sc);
    wait_edge(eb, e0);
    chk(e0 - sc >= 1 && e0 - sc <= 6, "R2 start on next tick", e0 - sc, 4);
    wait_n(900);
    check_frame(e0, 64'h0, "R1 first frame data zero");
    chk(n_irq == ib + 1, "R6 one irq per frame", n_irq - ib, 1);
    chk(irq_t[ib % 64] == e0 + 72 * 2 * HB, "R6 irq at cell 72 start",
        irq_t[ib % 64] - e0, 72 * 2 * HB);
    chk(edge_at(n_edge - 1) == e0 + 79 * 2 * HB + HB, "R10 idle after frame",
        edge_at(n_edge - 1) - e0, 79 * 2 * HB + HB);
  endtask

  task automatic t_second_frame();
    int eb, sc, e0;
    eb = n_edge;
    pulse_start(sc);
    wait_edge(eb, e0);
    wait_n(900);
    check_frame(e0, PAT_A, "R3 data order");
  endtask

  task automatic t_latency();
    int ib, tn;
    stage = PAT_C;
    start = 1'b1;
    ib = n_irq;
    for (int k = 0; k < 2000 && n_irq <= ib; k++) step();
    tn = irq_t[ib % 64];
    stage = PAT_D;
    wait_n(1500);
    check_frame(tn + 8 * 2 * HB, PAT_C, "R7 frame N+1 old word");
    check_frame(tn + 8 * 2 * HB + 160 * HB, PAT_D, "R7 frame N+2 new word");
    chk(irq_t[(ib + 1) % 64] - tn == 160 * HB, "R2 back-to-back frames",
        irq_t[(ib + 1) % 64] - tn, 160 * HB);
  endtask

  task automatic t_rate(input logic [1:0] r, input int n, input int total, input int lo, input int hi);
    int ib, d;
    rate = r;
    start = 1'b1;
    ib = n_irq;
    for (int k = 0; k < (n + 3) * 900 && n_irq < ib + n + 2; k++) step();
    d = irq_t[(ib + 1 + n) % 64] - irq_t[(ib + 1) % 64];
    chk(d == total, "R9 frame period", d, total);
    for (int k = 0; k < n; k++) begin
      d = irq_t[(ib + 2 + k) % 64] - irq_t[(ib + 1 + k) % 64];
      chk(d >= lo && d <= hi, "R9 single frame period", d, lo);
    end
  endtask

  task automatic t_disable_mid();
    int eb, ib, sc, e0;
    start = 1'b0;
    rate = 2'd3;
    wait_n(2000);
    stage = PAT_E;
    eb = n_edge;
    pulse_start(sc);
    wait_edge(eb, e0);
    wait_n(100);
    tx_en = 1'b0;
    ib = n_irq;
    wait_n(800);
    chk(n_irq == ib, "R8 no irq after disable", n_irq - ib, 0);
    chk(edge_at(n_edge - 1) == e0 + 79 * 2 * HB + HB, "R8 frame completes",
        edge_at(n_edge - 1) - e0, 79 * 2 * HB + HB);
    eb = n_edge;
    pulse_start(sc);
    wait_n(300);
    chk(n_edge == eb, "R8 strobe ignored while disabled", n_edge - eb, 0);
    tx_en = 1'b1;
    stage = PAT_F;
    wait_n(5);
    eb = n_edge;
    pulse_start(sc);
    wait_edge(eb, e0);
    wait_n(900);
    check_frame(e0, PAT_D, "R8 transfer suppressed");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_gating();
    t_first_frame();
    t_second_frame();
    t_latency();
    t_rate(2'd0, 2, 1600, 800, 800);
    t_rate(2'd1, 2, 1536, 768, 768);
    t_rate(2'd3, 2, 1280, 640, 640);
    t_rate(2'd2, 25, 16016, 640, 641);
    t_disable_mid();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule